// File: doc/BRIEF.md
# Configurable asynchronous serial transmitter

This block sends characters over one asynchronous serial line. Software or a sequencer writes three words. A mode word sets the bit-rate divisor, the character size, parity and the number of stop bits. A control word sets the enable, the interrupt source, clear-to-send gating and a one-shot initialise command. A data word holds the character. A one-entry holding buffer takes the character. The frame is built from it when it moves into the shift register, and the line is driven least significant bit first.

Two flags show the transmit state. One shows that the holding buffer can take another character. The other shows that the shifter is idle. A level interrupt follows whichever flag the control word selects. When clear-to-send gating is on, a character waiting in the buffer stays there until the active-low `cts_n` input is low. A frame already on the line is not affected. The `cts_n` input is taken to be synchronous to `clk`.

Top module: `uart_tx_core`

## Requirements
- R1: Every serial bit lasts 16 prescaler ticks. The divisor comes from mode[1:0]: 0 selects 1, 1 selects 8, 2 selects 32 and 3 selects 256. With data 0x0FF in 8-bit mode, the start bit is low for exactly 16 times the divisor in clock cycles.
- R2: The idle line is high. A frame is a low start bit, then the data bits least significant first, then the optional parity bit, then high stop bits.
- R3: mode[6:5] sets the character size: 00 is 7 bits, 01 is 8 bits and 10 is 9 bits. The unused code 11 acts as 8 bits. Data bits above the chosen size are neither sent nor counted in parity.
- R4: mode[4]=1 inserts a parity bit after the data. mode[3]=0 makes the number of ones in data plus parity even, and mode[3]=1 makes it odd.
- R5: mode[2]=0 sends one stop bit and mode[2]=1 sends two.
- R6: `buf_empty` is 1 when the holding buffer is free and 0 when it holds a character. A data write while the buffer is full is ignored.
- R7: `shift_done` is 0 while a frame is on the line and 1 otherwise.
- R8: If a character is waiting when the last stop bit ends, its start bit follows at once, with no idle time in between.
- R9: `tx_irq` equals `buf_empty` when ctrl[2]=0 and `shift_done` when ctrl[2]=1.
- R10: A character moves into the shifter only while ctrl[0] (enable) is 1. Clearing the enable lets the current frame finish and keeps the waiting character in the buffer.
- R11: When ctrl[3]=1, a waiting character is held while `cts_n` is high. Its frame starts on the first tick after `cts_n` goes low.
- R12: Writing the control word with ctrl[1]=1 empties the buffer, ends any frame and drives the line high on the next cycle. The mode word is kept.
- R13: After reset, `txd`, `buf_empty`, `shift_done` and `tx_irq` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Write strobe for the mode word |
| mode_wdata | input | 7 | Mode word: divisor [1:0], two stop [2], odd [3], parity on [4], size [6:5] |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 4 | Control word: enable [0], initialise [1], interrupt source [2], CTS gating [3] |
| data_we | input | 1 | Write strobe for the holding buffer |
| data_wdata | input | 9 | Character to send |
| cts_n | input | 1 | Clear-to-send, active low |
| txd | output | 1 | Serial output |
| buf_empty | output | 1 | Holding buffer free |
| shift_done | output | 1 | Shifter idle |
| tx_irq | output | 1 | Transmit interrupt level |

## Verification
The hardest state to reach from the ports is a full holding buffer at the moment a frame ends. In that state the handover decision depends on the enable and on `cts_n`. The bench writes a second character while the first frame is still being shifted, and a third to show that it is dropped. It then samples every bit centre across both frames, so that no idle gap or lost bit can go unseen. To cover the deferred cases, it leaves a character in the buffer with the enable cleared or `cts_n` high. It holds the line idle for a while and then releases the condition.

// File: rtl/uart_tx_core.sv
module uart_tx_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic [6:0] mode_wdata,
  input  logic       ctrl_we,
  input  logic [3:0] ctrl_wdata,
  input  logic       data_we,
  input  logic [8:0] data_wdata,
  input  logic       cts_n,
  output logic       txd,
  output logic       buf_empty,
  output logic       shift_done,
  output logic       tx_irq
);
  localparam int FW = 13;
  localparam int DW = 9;

  logic [6:0]    mode;
  logic          tx_en, irq_sel, cts_en;
  logic [7:0]    presc, lim;
  logic          tick, init_cmd, can_load, busy, hold_full, par;
  logic [DW-1:0] hold;
  logic [FW-1:0] sh, fr;
  logic [3:0]    left, sub, nb;
  int            len;

  always_comb begin
    case (mode[1:0])
      2'd0:    lim = 8'd0;
      2'd1:    lim = 8'd7;
      2'd2:    lim = 8'd31;
      default: lim = 8'd255;
    endcase
  end

  assign tick     = presc >= lim;
  assign init_cmd = ctrl_we & ctrl_wdata[1];
  assign can_load = hold_full & tx_en & (~cts_en | ~cts_n);

  always_comb begin
    case (mode[6:5])
      2'b00:   len = 7;
      2'b10:   len = 9;
      default: len = 8;
    endcase
    par = mode[3];
    fr = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (i < len) begin
        fr[4'(i + 1)] = hold[4'(i)];
        par = par ^ hold[4'(i)];
      end
    end
    if (mode[4]) fr[4'(len + 1)] = par;
    nb = 4'(2 + len + int'(mode[4]) + int'(mode[2]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= '0;
      tx_en   <= 1'b0;
      irq_sel <= 1'b0;
      cts_en  <= 1'b0;
    end else begin
      if (mode_we) mode <= mode_wdata;
      if (ctrl_we) {cts_en, irq_sel, tx_en} <= {ctrl_wdata[3], ctrl_wdata[2], ctrl_wdata[0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                presc <= '0;
    else if (init_cmd || tick) presc <= '0;
    else                       presc <= presc + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
      busy      <= 1'b0;
      sh        <= '1;
      left      <= '0;
      sub       <= '0;
    end else if (init_cmd) begin
      hold_full <= 1'b0;
      busy      <= 1'b0;
      sh        <= '1;
      left      <= '0;
      sub       <= '0;
    end else begin
      if (data_we && !hold_full) begin
        hold      <= data_wdata;
        hold_full <= 1'b1;
      end
      if (tick) begin
        if (busy && sub != 4'd15) begin
          sub <= sub + 4'd1;
        end else if (busy && left > 4'd1) begin
          sub  <= '0;
          sh   <= {1'b1, sh[FW-1:1]};
          left <= left - 4'd1;
        end else if (can_load) begin
          sh        <= fr;
          left      <= nb;
          sub       <= '0;
          busy      <= 1'b1;
          hold_full <= 1'b0;
        end else begin
          busy <= 1'b0;
          sh   <= '1;
        end
      end
    end
  end

  assign txd        = sh[0];
  assign buf_empty  = ~hold_full;
  assign shift_done = ~busy;
  assign tx_irq     = irq_sel ? shift_done : buf_empty;

  // R6
  buf_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_empty) |-> $past(data_we));

  // R10
  load_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_en));

  // R10
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && shift_done) |=> shift_done);

  // R11
  cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_en && cts_n && shift_done) |=> shift_done);

  // R1
  line_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !init_cmd) |=> $stable(txd));

  // R12
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_cmd |=> (buf_empty && shift_done && txd));
endmodule

// File: tb/uart_tx_core_bench.sv
module uart_tx_core_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_we = 1'b0, ctrl_we = 1'b0, data_we = 1'b0, cts_n = 1'b0;
  logic [6:0] mode_wdata = '0;
  logic [3:0] ctrl_wdata = '0;
  logic [8:0] data_wdata = '0;
  logic txd, buf_empty, shift_done, tx_irq;

  int checks = 0, errors = 0;
  int blen = 8, bpen = 0, bodd = 0, bst2 = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  uart_tx_core u_uart_tx_core (
    .clk(clk), .rst_n(rst_n),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .data_we(data_we), .data_wdata(data_wdata),
    .cts_n(cts_n),
    .txd(txd), .buf_empty(buf_empty), .shift_done(shift_done), .tx_irq(tx_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_mode(input logic [6:0] m);
    mode_wdata = m; mode_we = 1'b1;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic wr_ctrl(input bit en, input bit sel, input bit cts, input bit ini);
    ctrl_wdata = {cts, sel, ini, en}; ctrl_we = 1'b1;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr_data(input logic [8:0] d);
    data_wdata = d; data_we = 1'b1;
    @(negedge clk); data_we = 1'b0;
  endtask

  function automatic logic exp_bit(input int k, input logic [8:0] d);
    int ones;
    if (k == 0) return 1'b0;
    if (k <= blen) return d[k-1];
    if (bpen != 0 && k == blen + 1) begin
      ones = 0;
      for (int i = 0; i < blen; i++) ones += int'(d[i]);
      return logic'((ones % 2) ^ bodd);
    end
    return 1'b1;
  endfunction

  // Called at the negedge just after the start edge, minus skip cycles already spent.
  task automatic check_frame(input logic [8:0] d, input int skip, input string req);
    int nbits;
    nbits = 2 + blen + bpen + bst2;
    for (int k = 0; k < nbits; k++) begin
      repeat ((k == 0) ? (8 - skip) : 8) @(negedge clk);
      chk(txd == exp_bit(k, d), req, int'(txd), int'(exp_bit(k, d)));
      repeat (8) @(negedge clk);
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] pats [4];
    int cnt, div;
    bit stayed;
    pats[0] = 9'h155; pats[1] = 9'h0AA; pats[2] = 9'h1C3; pats[3] = 9'h13C;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13 reset state
    chk(txd == 1'b1, "R13 txd", int'(txd), 1);
    chk(buf_empty == 1'b1, "R13 buf_empty", int'(buf_empty), 1);
    chk(shift_done == 1'b1, "R13 shift_done", int'(shift_done), 1);
    chk(tx_irq == 1'b1, "R13 tx_irq", int'(tx_irq), 1);
    @(negedge clk);

    wr_ctrl(1'b1, 1'b0, 1'b0, 1'b0);
    // R2 R3 R4 R5 sweep over size, parity, polarity and stop count
    for (int l = 0; l < 4; l++)
      for (int p = 0; p < 2; p++)
        for (int o = 0; o < 2; o++)
          for (int s = 0; s < 2; s++) begin
            blen = (l == 0) ? 7 : (l == 2) ? 9 : 8;
            bpen = p; bodd = o; bst2 = s;
            wr_mode({2'(l), 1'(p), 1'(o), 1'(s), 2'b00});
            for (int di = 0; di < 4; di++) begin
              wr_data(pats[di]);
              @(negedge clk);
              // R7 shifting
              chk(shift_done == 1'b0, "R7 busy", int'(shift_done), 0);
              chk(buf_empty == 1'b1, "R6 moved", int'(buf_empty), 1);
              check_frame(pats[di], 0, "R2 R3 R4 R5 frame bit");
              chk(shift_done == 1'b1, "R7 done", int'(shift_done), 1);
            end
          end

    blen = 8; bpen = 0; bodd = 0; bst2 = 0;
    wr_mode(7'b0100000);

    // R6 R8: second char while busy, third dropped, back-to-back frames
    wr_data(9'h0A5);
    @(negedge clk);
    wr_data(9'h03C);
    chk(buf_empty == 1'b0, "R6 full", int'(buf_empty), 0);
    wr_data(9'h0FF);
    check_frame(9'h0A5, 2, "R8 first");
    check_frame(9'h03C, 0, "R8 second");
    chk(shift_done == 1'b1 && buf_empty == 1'b1, "R6 third dropped",
        int'({shift_done, buf_empty}), 3);
    stayed = 1'b1;
    repeat (40) begin @(negedge clk); if (txd != 1'b1) stayed = 1'b0; end
    chk(stayed, "R6 ignored write", int'(stayed), 1);

    // R9 interrupt source
    wr_data(9'h066);
    @(negedge clk);
    chk(tx_irq == 1'b1, "R9 buf source", int'(tx_irq), 1);
    wr_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
    chk(tx_irq == 1'b0, "R9 shift source", int'(tx_irq), 0);
    check_frame(9'h066, 1, "R9 frame");
    chk(tx_irq == 1'b1, "R9 shift done", int'(tx_irq), 1);
    wr_ctrl(1'b1, 1'b0, 1'b0, 1'b0);

    // R10 enable cleared mid-frame
    wr_data(9'h0C9);
    @(negedge clk);
    wr_ctrl(1'b0, 1'b0, 1'b0, 1'b0);
    check_frame(9'h0C9, 1, "R10 finish");
    chk(shift_done == 1'b1, "R10 done", int'(shift_done), 1);
    wr_data(9'h017);
    stayed = 1'b1;
    repeat (50) begin @(negedge clk); if (txd != 1'b1 || shift_done != 1'b1) stayed = 1'b0; end
    chk(stayed, "R10 held idle", int'(stayed), 1);
    chk(buf_empty == 1'b0, "R10 kept", int'(buf_empty), 0);
    wr_ctrl(1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check_frame(9'h017, 0, "R10 resume");

    // R11 clear-to-send gating
    wr_ctrl(1'b1, 1'b0, 1'b1, 1'b0);
    cts_n = 1'b1;
    wr_data(9'h0E1);
    stayed = 1'b1;
    repeat (40) begin @(negedge clk); if (txd != 1'b1 || shift_done != 1'b1) stayed = 1'b0; end
    chk(stayed, "R11 held", int'(stayed), 1);
    chk(buf_empty == 1'b0, "R11 waiting", int'(buf_empty), 0);
    cts_n = 1'b0;
    @(negedge clk);
    check_frame(9'h0E1, 0, "R11 released");
    wr_ctrl(1'b1, 1'b0, 1'b0, 1'b0);

    // R12 initialise mid-frame
    wr_data(9'h000);
    @(negedge clk);
    wr_data(9'h011);
    wr_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
    chk(txd == 1'b1, "R12 txd", int'(txd), 1);
    chk(buf_empty == 1'b1, "R12 buf", int'(buf_empty), 1);
    chk(shift_done == 1'b1, "R12 shift", int'(shift_done), 1);
    stayed = 1'b1;
    repeat (40) begin @(negedge clk); if (txd != 1'b1) stayed = 1'b0; end
    chk(stayed, "R12 discarded", int'(stayed), 1);

    // R1 prescaler sweep
    for (int s = 0; s < 4; s++) begin
      div = (s == 0) ? 1 : (s == 1) ? 8 : (s == 2) ? 32 : 256;
      wr_mode({2'b01, 3'b000, 2'(s)});
      wr_data(9'h0FF);
      cnt = 0;
      while (txd == 1'b1 && cnt < 2000) begin @(negedge clk); cnt++; end
      cnt = 0;
      while (txd == 1'b0 && cnt < 5000) begin @(negedge clk); cnt++; end
      chk(cnt == 16 * div, "R1 start bit length", cnt, 16 * div);
      cnt = 0;
      while (shift_done == 1'b0 && cnt < 50000) begin @(negedge clk); cnt++; end
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule